// File: doc/BRIEF.md
# Instruction Line Fill Buffer

This block holds one instruction line while it comes back from the system bus. Each returning beat carries a 3-bit word index, so the words can arrive in any order: target word first, ascending, or scrambled. The path is either 32 bits wide, with one word per beat, or 64 bits wide, with two words per beat. A fill fetches either a full eight-word line or a single four-word quadword. The target word that starts the fill picks which quadword.

Instruction fetches look up the buffer every cycle. A fetch hits when its line address matches the buffered line and its word is present. It returns one cycle later, which is the latency of a cache hit. This holds even while the rest of the line is still arriving, and even when the wanted word arrives in the same cycle as the lookup.

When the line is complete, the block decides whether to copy it into the instruction cache. It copies a cacheable eight-word line unless the fetch-without-allocate setting was given for that fill. A fill caused by a cache-block-touch operation is always copied. Lines that are not copied stay in the buffer and keep serving fetches until the next fill starts.

Top module: `ifill_buffer`

## Requirements
- R1: After reset no lookup hits, `lk_data` is 0 and `cw_valid` is 0.
- R2: On a 32-bit path (`bus_wide`=0) a beat writes `beat_data[31:0]` into word `beat_idx`. Words are accepted in any order.
- R3: On a 64-bit path (`bus_wide`=1) a beat ignores `beat_idx[0]`. It writes `beat_data[31:0]` into the even word `{beat_idx[2:1],0}` and `beat_data[63:32]` into the odd word above it.
- R4: A lookup registers its result one cycle later. `lk_hit` is 1 only when `lk_addr[LA_W+2:3]` equals the buffered line and word `lk_addr[2:0]` is present. On a miss `lk_data` is 0.
- R5: A lookup of a word that is being written in the same cycle hits and returns the new data.
- R6: `fill_start` clears every word, then loads the new line address and attributes. A beat given in the same cycle as `fill_start` is ignored.
- R7: A four-word fill (`fill_eight`=0) accepts only the quadword that holds `fill_target`, which is words 4..7 when `fill_target[2]`=1 and words 0..3 otherwise. Beats for other words are ignored. A four-word line is never written to the cache.
- R8: A non-cacheable line is never written to the cache. It keeps serving lookups until the next `fill_start`.
- R9: The cycle after the beat that completes a cacheable eight-word line, `cw_valid` pulses for exactly one cycle, with `cw_line` and all eight words in `cw_data` (word i at bits 32i+31:32i). The pulse happens only if `fill_no_alloc` was 0 at the start of the fill.
- R10: When `fill_touch` was 1 at the start of the fill, a complete cacheable eight-word line is written even if `fill_no_alloc` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_start | input | 1 | Begin a new line fill |
| fill_line | input | LA_W | Line address of the new fill |
| fill_eight | input | 1 | 1: eight-word line, 0: four-word quadword |
| fill_target | input | 3 | Target word; bit 2 picks the quadword of a four-word fill |
| fill_cacheable | input | 1 | Line is cacheable |
| fill_touch | input | 1 | Fill was caused by a cache-block-touch |
| fill_no_alloc | input | 1 | Fetch-without-allocate setting |
| bus_wide | input | 1 | 1: 64-bit return path, 0: 32-bit |
| beat_valid | input | 1 | Return beat present |
| beat_idx | input | 3 | Word index of the beat |
| beat_data | input | 2*WORD_W | Beat data |
| lk_valid | input | 1 | Fetch lookup request |
| lk_addr | input | LA_W+3 | Word address of the lookup |
| lk_hit | output | 1 | Lookup hit, one cycle after the request |
| lk_data | output | WORD_W | Looked-up word |
| cw_valid | output | 1 | One-cycle cache write strobe |
| cw_line | output | LA_W | Line address for the cache write |
| cw_data | output | 8*WORD_W | The eight words of the line |

## Verification
A return beat and a lookup of the very word that beat carries can fall in the same cycle. Every beat of every fill is driven together with such a lookup. On the 64-bit path the lookup alternates between the even word and the odd word of the pair. The bench expects a hit carrying the beat's data in the next cycle, not the stale miss that the stored valid bits alone would give. The sweep covers both path widths, both line sizes, every target word, two return orders and all attribute combinations. The completion strobe is checked in the same cycle as the final bypassed lookup.

// File: rtl/ifill_buffer.sv
module ifill_buffer #(
  parameter int LA_W   = 10,
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fill_start,
  input  logic [LA_W-1:0]       fill_line,
  input  logic                  fill_eight,
  input  logic [2:0]            fill_target,
  input  logic                  fill_cacheable,
  input  logic                  fill_touch,
  input  logic                  fill_no_alloc,
  input  logic                  bus_wide,
  input  logic                  beat_valid,
  input  logic [2:0]            beat_idx,
  input  logic [2*WORD_W-1:0]   beat_data,
  input  logic                  lk_valid,
  input  logic [LA_W+2:0]       lk_addr,
  output logic                  lk_hit,
  output logic [WORD_W-1:0]     lk_data,
  output logic                  cw_valid,
  output logic [LA_W-1:0]       cw_line,
  output logic [8*WORD_W-1:0]   cw_data
);
  localparam int NW = 8;

  logic [WORD_W-1:0] words [NW];
  logic [NW-1:0]     vmask, need, wr_en, new_mask;
  logic [LA_W-1:0]   tag;
  logic              is_eight, is_cach, do_alloc, done;

  wire [2:0]        lw       = lk_addr[2:0];
  wire              tag_hit  = lk_addr[LA_W+2:3] == tag;
  wire [WORD_W-1:0] lo_word  = beat_data[WORD_W-1:0];
  wire [WORD_W-1:0] hi_word  = beat_data[2*WORD_W-1:WORD_W];

  always_comb begin
    wr_en = '0;
    if (beat_valid && !fill_start) begin
      if (bus_wide) begin
        wr_en[{beat_idx[2:1], 1'b0}] = 1'b1;
        wr_en[{beat_idx[2:1], 1'b1}] = 1'b1;
      end else begin
        wr_en[beat_idx] = 1'b1;
      end
    end
    wr_en = wr_en & need;
  end

  assign new_mask = vmask | wr_en;

  wire              hit_c  = lk_valid && tag_hit && (vmask[lw] || wr_en[lw]);
  wire [WORD_W-1:0] byp_w  = (bus_wide && lw[0]) ? hi_word : lo_word;
  wire [WORD_W-1:0] data_c = wr_en[lw] ? byp_w : words[lw];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vmask    <= '0;
      need     <= '0;
      tag      <= '0;
      is_eight <= 1'b0;
      is_cach  <= 1'b0;
      do_alloc <= 1'b0;
      done     <= 1'b1;
      cw_valid <= 1'b0;
      lk_hit   <= 1'b0;
      lk_data  <= '0;
    end else begin
      cw_valid <= 1'b0;
      lk_hit   <= hit_c;
      lk_data  <= hit_c ? data_c : '0;
      if (fill_start) begin
        vmask    <= '0;
        tag      <= fill_line;
        need     <= fill_eight ? 8'hFF : (fill_target[2] ? 8'hF0 : 8'h0F);
        is_eight <= fill_eight;
        is_cach  <= fill_cacheable;
        do_alloc <= !fill_no_alloc || fill_touch;
        done     <= 1'b0;
      end else begin
        vmask <= new_mask;
        if (!done && (new_mask & need) == need) begin
          done     <= 1'b1;
          cw_valid <= is_eight && is_cach && do_alloc;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NW; i++)
      if (wr_en[i]) words[i] <= (bus_wide && i[0]) ? hi_word : lo_word;
  end

  assign cw_line = tag;

  for (genvar g = 0; g < NW; g++) begin : g_cw
    assign cw_data[g*WORD_W +: WORD_W] = words[g];
  end

endmodule

// File: rtl/ifill_buffer_chk.sv
module ifill_buffer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fill_start,
  input logic       lk_valid,
  input logic       lk_hit,
  input logic       cw_valid,
  input logic [7:0] vmask,
  input logic       is_eight,
  input logic       is_cach,
  input logic       do_alloc
);
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cw_valid |=> !cw_valid); // R9
  AST_FULL_LINE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) cw_valid |-> vmask == 8'hFF); // R9
  AST_NC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) cw_valid |-> (is_cach && is_eight)); // R8
  AST_ALLOC_GATE: assert property (@(posedge clk) disable iff (!rst_n) cw_valid |-> do_alloc); // R10
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) fill_start |=> vmask == 8'h00); // R6
  AST_HIT_HAS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n) lk_hit |-> $past(lk_valid)); // R4
endmodule

bind ifill_buffer ifill_buffer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fill_start(fill_start), .lk_valid(lk_valid),
  .lk_hit(lk_hit), .cw_valid(cw_valid), .vmask(vmask), .is_eight(is_eight),
  .is_cach(is_cach), .do_alloc(do_alloc)
);

// File: tb/ifill_buffer_test.sv
module ifill_buffer_test;
  localparam int LA_W = 10;
  localparam int WW   = 32;

  logic clk = 0, rst_n = 0;
  logic fill_start = 0, fill_eight = 0, fill_cacheable = 0, fill_touch = 0, fill_no_alloc = 0;
  logic [LA_W-1:0] fill_line = '0;
  logic [2:0] fill_target = '0, beat_idx = '0;
  logic bus_wide = 0, beat_valid = 0, lk_valid = 0;
  logic [2*WW-1:0] beat_data = '0;
  logic [LA_W+2:0] lk_addr = '0;
  logic lk_hit, cw_valid;
  logic [WW-1:0] lk_data;
  logic [LA_W-1:0] cw_line;
  logic [8*WW-1:0] cw_data;

  int n_cmp = 0, n_bad = 0;
  bit ended = 0;

  ifill_buffer #(.LA_W(LA_W), .WORD_W(WW)) uut (.*);

  always #4 clk = ~clk;

  function automatic logic [WW-1:0] word_of(int line, int w);
    logic [15:0] k;
    k = {line[7:0], 8'(w)};
    return {k, k ^ 16'hA5C3};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [8*WW-1:0] act, logic [8*WW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic look(int line, int w, bit exp_hit, string req);
    logic [WW-1:0] ed;
    @(negedge clk);
    lk_valid = 1; lk_addr = {LA_W'(line), 3'(w)};
    @(negedge clk);
    lk_valid = 0;
    ed = exp_hit ? word_of(line, w) : '0;
    chk(lk_hit == exp_hit, req, "lookup hit", 256'(lk_hit), 256'(exp_hit));
    chk(lk_data == ed, req, "lookup data", 256'(lk_data), 256'(ed));
  endtask

  task automatic fill(int line, bit eight, bit cach, bit na, bit touch, int target, bit wide, int step);
    int n, qbase, stride, tslot, w, lw;
    logic [7:0] ev, need;
    bit alloc, last;
    logic [8*WW-1:0] el;
    qbase  = eight ? 0 : (target & 4);
    stride = wide ? 2 : 1;
    n      = (eight ? 8 : 4) / stride;
    tslot  = (target - qbase) / stride;
    need   = eight ? 8'hFF : ((target & 4) != 0 ? 8'hF0 : 8'h0F);
    alloc  = eight && cach && (!na || touch);
    @(negedge clk);
    fill_start = 1; fill_line = LA_W'(line); fill_eight = eight; fill_target = 3'(target);
    fill_cacheable = cach; fill_touch = touch; fill_no_alloc = na; bus_wide = wide;
    beat_valid = 1; beat_idx = 3'(target);
    beat_data = {word_of(line, target | 1), word_of(line, target & 6)};
    @(negedge clk);
    fill_start = 0; beat_valid = 0;
    look(line, target, 0, "R6");
    look(line - 1, target, 0, "R6");
    ev = '0;
    for (int k = 0; k < n; k++) begin
      int slot;
      slot = (tslot + k * step) % n;
      w    = qbase + slot * stride;
      lw   = w + (wide ? (k % 2) : 0);
      last = (k == n - 1);
      @(negedge clk);
      beat_valid = 1;
      beat_idx   = 3'(wide ? (w | (k & 1)) : w);
      beat_data  = wide ? {word_of(line, w + 1), word_of(line, w)} : {32'hDEAD_BEEF, word_of(line, w)};
      lk_valid = 1; lk_addr = {LA_W'(line), 3'(lw)};
      ev[w] = 1'b1;
      if (wide) ev[w + 1] = 1'b1;
      @(negedge clk);
      beat_valid = 0; lk_valid = 0;
      chk(lk_hit == 1'b1, wide ? "R3" : "R2", "bypass hit R5", 256'(lk_hit), 256'(1));
      chk(lk_data == word_of(line, lw), "R5", "bypass data", 256'(lk_data), 256'(word_of(line, lw)));
      chk(cw_valid == (last && alloc), eight ? (touch ? "R10" : "R9") : "R7", "write strobe",
          256'(cw_valid), 256'(last && alloc));
      if (last && alloc) begin
        for (int i = 0; i < 8; i++) el[i*WW +: WW] = word_of(line, i);
        chk(cw_line == LA_W'(line), "R9", "write line", 256'(cw_line), 256'(LA_W'(line)));
        chk(cw_data == el, "R9", "write data", cw_data, el);
      end
      if (!last) begin
        int pw;
        pw = (k * 3 + 1) % 8;
        look(line, pw, ev[pw], "R4");
      end else begin
        @(negedge clk);
        chk(cw_valid == 1'b0, "R9", "strobe width", 256'(cw_valid), 256'(0));
      end
    end
    if (!eight) begin
      @(negedge clk);
      beat_valid = 1; beat_idx = 3'(target ^ 4);
      beat_data = {word_of(line, (target ^ 4) | 1), word_of(line, (target ^ 4) & 6)};
      @(negedge clk);
      beat_valid = 0;
      chk(cw_valid == 1'b0, "R7", "stray beat strobe", 256'(cw_valid), 256'(0));
      look(line, target ^ 4, 0, "R7");
    end
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) look(line, i, need[i], cach ? "R4" : "R8");
    look(line + 1, target, 0, "R4");
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int line;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cw_valid == 1'b0, "R1", "reset strobe", 256'(cw_valid), 256'(0));
    look(0, 0, 0, "R1");
    line = 5;
    for (int wide = 0; wide < 2; wide++)
      for (int eight = 0; eight < 2; eight++)
        for (int attr = 0; attr < 8; attr++)
          for (int t = 0; t < 8; t++)
            for (int s = 0; s < 2; s++) begin
              fill(line, eight[0], attr[0], attr[1], attr[2], t, wide[0], s ? 3 : 1);
              line += 2;
            end
    finish_run();
  end
endmodule